// File: doc/BRIEF.md
# Descriptor Ring Poll Engine

This block keeps a network controller informed about buffer descriptors that software has handed over in memory. It holds one receive ring and one transmit ring. For each ring it keeps a base address, a length code and a current index. For the receive ring it also tracks the descriptor after the current one. Each descriptor is 16 bytes. While the line and the data movers are idle and the poll interval has run out, the engine asks for the system bus and reads the descriptor words it still needs. It latches a descriptor's contents into its status registers only when the descriptor turns out to be owned by the hardware.

A receive check and a transmit check each run under their own bus tenure. The request drops for at least one cycle between the two. The receive check and the transmit check can each be switched off on their own. The data-movement logic outside this block tells the engine when it has finished with a descriptor, using an advance pulse. The engine then steps to the next ring entry.

Top module: `desc_poll_engine`

## Requirements
- R1: A poll starts only when `line_busy`, `rx_move_busy` and `tx_move_busy` are all low and the poll interval has elapsed. While any of them is high, `bus_req` stays low.
- R2: While `tx_poll_off` is 1, no transmit descriptor is read and no bus request is made for one.
- R3: While `rx_on` is 0, no receive descriptor is read.
- R4: Ring length is 2 to the power of the 4-bit length code, capped at 2 to the power of IW, and indices wrap to 0 after the last entry. A receive poll reads the current entry if it is not owned. Otherwise it reads the next entry, provided the ring has more than one entry and the next entry is not owned.
- R5: When no receive descriptor needs reading, a poll reads only the current transmit descriptor. When nothing at all needs reading, no bus request is made.
- R6: Word k of entry i lies at base + 16*i + 4*k. Each descriptor is read word 1 first and then word 0, under one held request. The receive read comes before the transmit read. `bus_req` is low for at least one cycle between the two tenures.
- R7: Bit 31 of word 1 is the ownership bit. Status registers and ownership flags are updated only when that bit is 1. Otherwise they keep their previous values.
- R8: The interval counter restarts from zero when a poll completes, and a poll becomes due once the counter reaches `poll_period`. A pulse on `poll_now` makes a poll due at once.
- R9: If activity appears while the engine is waiting for a grant, `bus_req` is withdrawn on the next cycle and no read is issued.
- R10: `rx_advance` steps the receive index. The next entry's ownership flag and words then become the current ones, and the next flag clears. `tx_advance` steps the transmit index and clears the transmit ownership flag.
- R11: After reset, every index, ownership flag and status word is 0, and `bus_req`, `rd_en` and `poll_busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_on | input | 1 | Receiver enabled; allows receive polling |
| tx_poll_off | input | 1 | Suppresses transmit polling |
| line_busy | input | 1 | Network channel activity |
| rx_move_busy | input | 1 | Receive pre/post processing in progress |
| tx_move_busy | input | 1 | Transmit pre/post processing in progress |
| poll_period | input | TW | Poll interval in cycles |
| poll_now | input | 1 | Makes a poll due immediately |
| rx_ring_base | input | AW | Receive ring base address |
| tx_ring_base | input | AW | Transmit ring base address |
| rx_len_code | input | 4 | Receive ring length code |
| tx_len_code | input | 4 | Transmit ring length code |
| rx_advance | input | 1 | Current receive descriptor consumed |
| tx_advance | input | 1 | Current transmit descriptor consumed |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| rd_en | output | 1 | Read strobe, one cycle per read |
| rd_addr | output | AW | Read address |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | 32 | Read data |
| poll_busy | output | 1 | A poll is in progress |
| rx_idx | output | IW | Current receive index |
| tx_idx | output | IW | Current transmit index |
| rx_cur_own | output | 1 | Current receive descriptor is owned |
| rx_nxt_own | output | 1 | Next receive descriptor is owned |
| tx_cur_own | output | 1 | Current transmit descriptor is owned |
| rx_cur_w1 | output | 32 | Current receive descriptor word 1 |
| rx_cur_w0 | output | 32 | Current receive descriptor word 0 |
| tx_cur_w1 | output | 32 | Current transmit descriptor word 1 |
| tx_cur_w0 | output | 32 | Current transmit descriptor word 0 |

## Verification
The assertions rely on three things about the inputs:
- The arbiter keeps `bus_gnt` asserted for as long as `bus_req` stays high after granting it.
- Exactly one `rd_rvalid` pulse answers each `rd_en`, and it arrives only after the strobe.
- Advance pulses arrive only while `poll_busy` is low.

The bench's bus model grants one cycle after a request and stops granting once the request drops. Its memory model returns data exactly one cycle after each strobe. The bench issues advance pulses and changes configuration only between polls, once it has seen `poll_busy` low.

// File: rtl/desc_poll_engine.sv
module desc_poll_engine #(
  parameter int AW = 32,
  parameter int TW = 16,
  parameter int IW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_on,
  input  logic          tx_poll_off,
  input  logic          line_busy,
  input  logic          rx_move_busy,
  input  logic          tx_move_busy,
  input  logic [TW-1:0] poll_period,
  input  logic          poll_now,
  input  logic [AW-1:0] rx_ring_base,
  input  logic [AW-1:0] tx_ring_base,
  input  logic [3:0]    rx_len_code,
  input  logic [3:0]    tx_len_code,
  input  logic          rx_advance,
  input  logic          tx_advance,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_rvalid,
  input  logic [31:0]   rd_rdata,
  output logic          poll_busy,
  output logic [IW-1:0] rx_idx,
  output logic [IW-1:0] tx_idx,
  output logic          rx_cur_own,
  output logic          rx_nxt_own,
  output logic          tx_cur_own,
  output logic [31:0]   rx_cur_w1,
  output logic [31:0]   rx_cur_w0,
  output logic [31:0]   tx_cur_w1,
  output logic [31:0]   tx_cur_w0
);

  typedef enum logic [2:0] {
    S_IDLE, S_RXQ, S_RX1, S_RX0, S_REL, S_TXQ, S_TX1, S_TX0
  } st_t;

  function automatic logic [IW-1:0] len_mask(input logic [3:0] code);
    logic [IW-1:0] m;
    m = '0;
    for (int b = 0; b < IW; b++)
      if (b < int'(code)) m[b] = 1'b1;
    return m;
  endfunction

  st_t           state, state_d;
  logic [TW-1:0] tmr;
  logic          pend, sel_nxt;
  logic [31:0]   hold_w1, rx_nxt_w1, rx_nxt_w0;
  logic [IW-1:0] rx_nidx, tx_nidx, tgt_idx;
  logic [AW-1:0] tgt_base;

  wire quiet   = !line_busy && !rx_move_busy && !tx_move_busy;
  wire elapsed = tmr >= poll_period;
  wire rx_multi = rx_len_code != 4'd0;
  wire rx_need = rx_on && (!rx_cur_own || (rx_multi && !rx_nxt_own));
  wire tx_need = !tx_poll_off && !tx_cur_own;
  wire got     = pend && rd_rvalid;
  wire word1   = (state == S_RX1) || (state == S_TX1);
  wire in_rx   = (state == S_RX1) || (state == S_RX0);
  wire in_read = in_rx || (state == S_TX1) || (state == S_TX0);

  assign rx_nidx   = (rx_idx + 1'b1) & len_mask(rx_len_code);
  assign tx_nidx   = (tx_idx + 1'b1) & len_mask(tx_len_code);
  assign tgt_idx   = in_rx ? (sel_nxt ? rx_nidx : rx_idx) : tx_idx;
  assign tgt_base  = in_rx ? rx_ring_base : tx_ring_base;
  assign rd_addr   = tgt_base + AW'({tgt_idx, 4'b0000}) + AW'({word1, 2'b00});
  assign rd_en     = in_read && !pend;
  assign bus_req   = (state != S_IDLE) && (state != S_REL);
  assign poll_busy = state != S_IDLE;

  logic done;
  always_comb begin
    state_d = state;
    done    = 1'b0;
    unique case (state)
      S_IDLE: if (elapsed && quiet) begin
        if (rx_need)      state_d = S_RXQ;
        else if (tx_need) state_d = S_TXQ;
        else              done = 1'b1;
      end
      S_RXQ: if (!quiet) state_d = S_IDLE;
             else if (bus_gnt) state_d = S_RX1;
      S_RX1: if (got) state_d = S_RX0;
      S_RX0: if (got) state_d = S_REL;
      S_REL: if (tx_need && quiet) state_d = S_TXQ;
             else if (tx_need) state_d = S_IDLE;
             else begin state_d = S_IDLE; done = 1'b1; end
      S_TXQ: if (!quiet) state_d = S_IDLE;
             else if (bus_gnt) state_d = S_TX1;
      S_TX1: if (got) state_d = S_TX0;
      S_TX0: if (got) begin state_d = S_IDLE; done = 1'b1; end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      tmr <= '0;
      pend <= 1'b0;
      sel_nxt <= 1'b0;
      hold_w1 <= '0;
      rx_idx <= '0;
      tx_idx <= '0;
      rx_cur_own <= 1'b0;
      rx_nxt_own <= 1'b0;
      tx_cur_own <= 1'b0;
      rx_cur_w1 <= '0;
      rx_cur_w0 <= '0;
      rx_nxt_w1 <= '0;
      rx_nxt_w0 <= '0;
      tx_cur_w1 <= '0;
      tx_cur_w0 <= '0;
    end else begin
      state <= state_d;
      if (poll_now)      tmr <= poll_period;
      else if (done)     tmr <= '0;
      else if (!elapsed) tmr <= tmr + 1'b1;
      if (rd_en)    pend <= 1'b1;
      else if (got) pend <= 1'b0;
      if (state == S_IDLE && state_d == S_RXQ) sel_nxt <= rx_cur_own;
      if (got && word1) hold_w1 <= rd_rdata;
      if (got && state == S_RX0 && hold_w1[31]) begin
        if (sel_nxt) begin
          rx_nxt_own <= 1'b1; rx_nxt_w1 <= hold_w1; rx_nxt_w0 <= rd_rdata;
        end else begin
          rx_cur_own <= 1'b1; rx_cur_w1 <= hold_w1; rx_cur_w0 <= rd_rdata;
        end
      end
      if (got && state == S_TX0 && hold_w1[31]) begin
        tx_cur_own <= 1'b1; tx_cur_w1 <= hold_w1; tx_cur_w0 <= rd_rdata;
      end
      if (rx_advance) begin
        rx_idx <= rx_nidx;
        rx_nxt_own <= 1'b0;
        if (rx_multi) begin
          rx_cur_own <= rx_nxt_own; rx_cur_w1 <= rx_nxt_w1; rx_cur_w0 <= rx_nxt_w0;
        end else begin
          rx_cur_own <= 1'b0;
        end
      end
      if (tx_advance) begin
        tx_idx <= tx_nidx;
        tx_cur_own <= 1'b0;
      end
    end
  end

  AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(quiet)); // R1
  AST_TX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TXQ && $past(state) != S_TXQ) |-> !$past(tx_poll_off)); // R2
  AST_RX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RXQ && $past(state) != S_RXQ) |-> $past(rx_on)); // R3
  AST_READ_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (bus_req && bus_gnt)); // R6
  AST_OWN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_cur_own) |-> ($past(rd_rvalid) && $past(hold_w1[31]))); // R7
  AST_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !rd_en && !pend && !bus_gnt && !quiet && !in_read) |=> !bus_req); // R9
  AST_ADV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_advance || tx_advance) |-> !poll_busy); // R10

endmodule

// File: tb/desc_poll_engine_tb_top.sv
module desc_poll_engine_tb_top;
  localparam int AW = 32, TW = 16, IW = 9;
  localparam logic [31:0] RXB = 32'h1000, TXB = 32'h2000;

  logic clk = 0, rst_n = 0;
  logic rx_on = 1, tx_poll_off = 0, line_busy = 0, rx_move_busy = 0, tx_move_busy = 0;
  logic [TW-1:0] poll_period = 16'd60000;
  logic poll_now = 0, rx_advance = 0, tx_advance = 0;
  logic [3:0] rx_len_code = 4'd2, tx_len_code = 4'd2;
  logic bus_req, bus_gnt = 0, rd_en, rd_rvalid = 0, poll_busy;
  logic [AW-1:0] rd_addr;
  logic [31:0] rd_rdata = 0;
  logic [IW-1:0] rx_idx, tx_idx;
  logic rx_cur_own, rx_nxt_own, tx_cur_own;
  logic [31:0] rx_cur_w1, rx_cur_w0, tx_cur_w1, tx_cur_w0;

  always #5 clk = ~clk;

  desc_poll_engine #(.AW(AW), .TW(TW), .IW(IW)) dut_i (
    .clk, .rst_n, .rx_on, .tx_poll_off, .line_busy, .rx_move_busy, .tx_move_busy,
    .poll_period, .poll_now, .rx_ring_base(RXB), .tx_ring_base(TXB),
    .rx_len_code, .tx_len_code, .rx_advance, .tx_advance,
    .bus_req, .bus_gnt, .rd_en, .rd_addr, .rd_rvalid, .rd_rdata, .poll_busy,
    .rx_idx, .tx_idx, .rx_cur_own, .rx_nxt_own, .tx_cur_own,
    .rx_cur_w1, .rx_cur_w0, .tx_cur_w1, .tx_cur_w0);

  int checks = 0, fails = 0, cyc = 0, req_rises = 0;
  logic [31:0] rxm [16][2];
  logic [31:0] txm [16][2];
  logic [31:0] exp_q [$];
  logic gnt_en = 1, rsp_pend = 0, prev_req = 0, last_rx0 = 0, drop_seen = 0;
  logic [31:0] rsp_data = 0;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (a >= TXB) return txm[(a - TXB) >> 4][(a >> 2) & 1];
    return rxm[(a - RXB) >> 4][(a >> 2) & 1];
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      bus_gnt <= bus_req && gnt_en;
      rd_rvalid <= rsp_pend;
      rd_rdata <= rsp_data;
      rsp_pend <= rd_en;
      if (bus_req && !prev_req) req_rises++;
      prev_req = bus_req;
      if (!bus_req) drop_seen = 1;
      if (rd_en) begin
        rsp_data <= mem_rd(rd_addr);
        if (exp_q.size() == 0) chk(0, "R6 unexpected read", rd_addr, 0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(rd_addr == e, "R6 read address/order", rd_addr, e);
        end
        if (last_rx0 && rd_addr >= TXB && rd_addr[2])
          chk(drop_seen, "R6 request gap between tenures", 0, 1);
        last_rx0 = (rd_addr < TXB) && !rd_addr[2];
        if (last_rx0) drop_seen = 0;
      end
    end
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic push_rx(input int i);
    exp_q.push_back(RXB + 16 * i + 4); exp_q.push_back(RXB + 16 * i);
  endtask
  task automatic push_tx(input int i);
    exp_q.push_back(TXB + 16 * i + 4); exp_q.push_back(TXB + 16 * i);
  endtask
  task automatic kick();
    @(negedge clk) poll_now = 1;
    @(negedge clk) poll_now = 0;
  endtask
  task automatic drain(input string req, input int maxc);
    int n = 0;
    while ((exp_q.size() != 0 || poll_busy) && n < maxc) begin @(negedge clk); n++; end
    chk(n < maxc, req, n, maxc);
    exp_q.delete();
    repeat (3) @(negedge clk);
  endtask
  task automatic no_req(input string req, input int n);
    int r0 = req_rises;
    repeat (n) @(negedge clk);
    chk(req_rises == r0 && !bus_req, req, req_rises - r0, 0);
  endtask

  initial begin
    foreach (rxm[i, j]) rxm[i][j] = 0;
    foreach (txm[i, j]) txm[i][j] = 0;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(!bus_req && !rd_en && !poll_busy, "R11 bus idle", {bus_req, rd_en, poll_busy}, 0);
    chk(rx_idx == 0 && tx_idx == 0 && !rx_cur_own && !rx_nxt_own && !tx_cur_own,
        "R11 indices/flags", {rx_idx, tx_idx}, 0);
    chk(rx_cur_w1 == 0 && tx_cur_w1 == 0 && rx_cur_w0 == 0 && tx_cur_w0 == 0, "R11 status", rx_cur_w1, 0);
    @(negedge clk) rst_n = 1;
    repeat (3) @(negedge clk);

    rxm[0][1] = 32'h8000_0A01; rxm[0][0] = 32'h1111_0000;
    txm[0][1] = 32'h0000_0B02; txm[0][0] = 32'h2222_0000;
    push_rx(0); push_tx(0); kick(); drain("R6 first poll", 200);
    chk(rx_cur_own && rx_cur_w1 == 32'h8000_0A01, "R7 rx stored", rx_cur_w1, 32'h8000_0A01);
    chk(rx_cur_w0 == 32'h1111_0000, "R7 rx word0", rx_cur_w0, 32'h1111_0000);
    chk(!tx_cur_own && tx_cur_w1 == 0, "R7 unowned tx not stored", tx_cur_w1, 0);

    rxm[1][1] = 32'h8000_0C03; rxm[1][0] = 32'h3333_0000;
    push_rx(1); push_tx(0); kick(); drain("R4 next-entry poll", 200);
    chk(rx_nxt_own && rx_cur_w1 == 32'h8000_0A01, "R4 next owned, current kept", rx_cur_w1, 32'h8000_0A01);

    txm[0][1] = 32'h8000_0D04; txm[0][0] = 32'h4444_0000;
    push_tx(0); kick(); drain("R5 transmit-only poll", 200);
    chk(tx_cur_own && tx_cur_w1 == 32'h8000_0D04 && tx_cur_w0 == 32'h4444_0000,
        "R5 tx stored", tx_cur_w1, 32'h8000_0D04);

    kick(); no_req("R5 nothing needed", 40);

    @(negedge clk) tx_advance = 1;
    @(negedge clk) tx_advance = 0;
    chk(tx_idx == 1 && !tx_cur_own, "R10 tx advance", tx_idx, 1);
    tx_poll_off = 1;
    kick(); no_req("R2 transmit poll off", 40);
    tx_poll_off = 0;
    txm[1][1] = 32'h0000_0E05;
    push_tx(1); kick(); drain("R2 transmit poll on", 200);
    chk(tx_cur_w1 == 32'h8000_0D04 && !tx_cur_own, "R7 status kept", tx_cur_w1, 32'h8000_0D04);

    @(negedge clk) rx_advance = 1;
    @(negedge clk) rx_advance = 0;
    chk(rx_idx == 1 && rx_cur_own && !rx_nxt_own && rx_cur_w1 == 32'h8000_0C03,
        "R10 rx advance", rx_cur_w1, 32'h8000_0C03);
    rx_on = 0;
    push_tx(1); kick(); drain("R3 receiver off", 200);
    rx_on = 1;
    push_rx(2); push_tx(1); kick(); drain("R3 receiver on", 200);

    gnt_en = 0;
    kick(); repeat (5) @(negedge clk);
    chk(bus_req, "R9 request pending", bus_req, 1);
    line_busy = 1;
    repeat (2) @(negedge clk);
    chk(!bus_req && !rd_en, "R9 request withdrawn", bus_req, 0);
    gnt_en = 1;
    push_rx(2); push_tx(1);
    line_busy = 0;
    drain("R9 retry after withdraw", 200);

    rx_move_busy = 1;
    kick(); no_req("R1 blocked by activity", 20);
    push_rx(2); push_tx(1);
    rx_move_busy = 0;
    drain("R1 start after idle", 200);

    poll_period = 16'd80;
    no_req("R8 interval not yet elapsed", 50);
    push_rx(2); push_tx(1);
    drain("R8 interval poll", 100);
    poll_period = 16'd60000;

    rxm[2][1] = 32'h8000_0F06; rxm[2][0] = 32'h6666_0000;
    push_rx(2); push_tx(1); kick(); drain("R4 next owned now", 200);
    tx_len_code = 4'd1;
    @(negedge clk) begin tx_advance = 1; rx_advance = 1; end
    @(negedge clk) begin tx_advance = 0; rx_advance = 0; end
    chk(tx_idx == 0, "R4 tx index wraps", tx_idx, 0);
    chk(rx_idx == 2 && rx_cur_w1 == 32'h8000_0F06, "R10 rx advance again", rx_idx, 2);
    rx_len_code = 4'd0;
    push_tx(0); kick(); drain("R4 one-entry ring ignores next", 200);
    chk(tx_cur_own && tx_cur_w1 == 32'h8000_0D04, "R7 tx owned again", tx_cur_w1, 32'h8000_0D04);
    rx_len_code = 4'd2;
    push_rx(3); kick(); drain("R4 multi-entry ring polls next", 200);
    chk(!rx_nxt_own, "R7 unowned next not stored", rx_nxt_own, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule